// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Resolver with Acknowledge Sequencer

This block is the request-handling heart of an eight-input interrupt controller. Eight request lines feed a pending register, either by latching rising edges or by following the line level. A mask vector keeps chosen lines out of arbitration. A priority resolver compares the best unmasked pending request with the best level already in service and raises `int_out` toward the processor only when the new request ranks strictly above everything in service. The ranking is fixed (line 0 first, line 7 last) or rotating: in rotating operation the level whose service just ended becomes the lowest.

The processor answers `int_out` with a train of acknowledge pulses on `inta`. On the first pulse the winning level moves from pending to in-service. The pulses then return the vector bytes for the configured processor family. In the 16-bit mode there are two pulses, and the second returns a type number. In the 8-bit mode there are three pulses, returning a call opcode and then two address bytes. Service ends at the last pulse when automatic end-of-interrupt is on. Otherwise it ends through a command strobe that frees either the top in-service level or a named level.

The sequencer is a three-state machine. `ACK_IDLE` waits for the first pulse, which is the grant transition, and moves to `ACK_SECOND`. From `ACK_SECOND` the second pulse returns to `ACK_IDLE` in 16-bit mode, or moves on to `ACK_THIRD` in 8-bit mode. From `ACK_THIRD` the third pulse returns to `ACK_IDLE`. While the machine is outside `ACK_IDLE`, `int_out` is held low.

Top module: `irq_prio_ack`

## Requirements
- R1: With `cfg_level`=0, a rising edge on an `irq_in` line latches its pending bit. The bit stays set after the line falls, until that level is acknowledged.
- R2: With `cfg_level`=1, the pending bit follows the line one clock later. A request that drops before acknowledge withdraws `int_out`.
- R3: A line whose `mask_in` bit is 1 never causes `int_out`. A masked line that was latched raises `int_out` once it is unmasked.
- R4: In fixed order (`cfg_rotate`=0), line 0 has the highest rank and line 7 the lowest. The top-ranked unmasked pending line wins.
- R5: `int_out` is high only when an unmasked pending line ranks strictly above every in-service level.
- R6: The first `inta` pulse moves the winning level into service and clears its edge-latched pending bit. Each clock grants at most one new level.
- R7: With `cfg_mode86`=1, the first pulse returns no byte and the second returns `{cfg_vbase[4:0], level[2:0]}`. Each byte appears with `vec_valid` for one clock after its pulse.
- R8: With `cfg_mode86`=0, three pulses return 8'hCD, then `{cfg_call_lo[2:0], level[2:0], 2'b00}`, then `cfg_call_hi`.
- R9: With `cfg_aeoi`=1, the acknowledged level leaves service at the last pulse.
- R10: An `eoi_cmd` strobe with `eoi_spec`=0 frees the top-ranked in-service level only.
- R11: An `eoi_cmd` strobe with `eoi_spec`=1 frees the level given by `eoi_lvl`.
- R12: With `cfg_rotate`=1, a level freed by any end-of-interrupt becomes the lowest rank. The remaining levels follow it in ascending circular order.
- R13: If no unmasked pending line exists at the first pulse, the sequence answers as level 7 and leaves the in-service set unchanged.
- R14: `int_out` stays low from the first pulse until the last pulse of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, bit n is level n |
| mask_in | input | 8 | 1 removes a line from arbitration |
| cfg_level | input | 1 | 1 = level-sensed requests, 0 = edge-latched |
| cfg_mode86 | input | 1 | 1 = two-pulse type-number mode, 0 = three-pulse call mode |
| cfg_aeoi | input | 1 | Automatic end of interrupt at last pulse |
| cfg_rotate | input | 1 | Freed level drops to lowest rank |
| cfg_vbase | input | 5 | Upper bits of the type number |
| cfg_call_lo | input | 3 | Upper bits of the call low address byte |
| cfg_call_hi | input | 8 | Call high address byte |
| eoi_cmd | input | 1 | End-of-interrupt command strobe |
| eoi_spec | input | 1 | 1 = free `eoi_lvl`, 0 = free top in-service level |
| eoi_lvl | input | 3 | Level freed by a specific command |
| inta | input | 1 | Acknowledge pulse, one clock per pulse |
| int_out | output | 1 | Interrupt request toward the processor |
| vec_valid | output | 1 | `vec_data` carries a byte this clock |
| vec_data | output | 8 | Returned vector byte |

## Verification
The hardest state to reach is one where several levels are in service at once, with a lower pending line blocked behind them. The in-service set has no read path, so it can only be seen through whether `int_out` rises. The stimulus builds the nest deliberately, with automatic end-of-interrupt off: it acknowledges a middle level, then raises a lower line and checks that it is held off, then raises a higher line and checks that it breaks through. It then peels the nest with generic and specific commands. After each command, the blocked line rising or staying low shows which level left service. Rotation is reached the same way: requests are raised after selected levels are freed, and the grant order shows where the lowest rank now sits.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_IRQ  = 8;
    localparam int LVL_W    = $clog2(NUM_IRQ);
    localparam int BYTE_W   = 8;
    localparam int VBASE_W  = BYTE_W - LVL_W;
    localparam int CALLLO_W = BYTE_W - LVL_W - 2;
    localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;
    localparam logic [LVL_W-1:0]  LVL_LAST    = LVL_W'(NUM_IRQ - 1);

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_SECOND = 2'd1,
        ACK_THIRD  = 2'd2
    } ack_state_e;

    // rank 0 = level just above 'lowest'; NUM_IRQ means empty vector
    function automatic logic [LVL_W:0] prio_rank(
        input logic [NUM_IRQ-1:0] vec,
        input logic [LVL_W-1:0]   lowest
    );
        logic [LVL_W:0]   r;
        logic [LVL_W-1:0] idx;
        r = (LVL_W+1)'(NUM_IRQ);
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            idx = lowest + LVL_W'(k + 1);
            if (vec[idx]) r = (LVL_W+1)'(k);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_request_reg.sv
module irq_request_reg
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               level_mode,
    input  logic               clr_en,
    input  logic [LVL_W-1:0]   clr_lvl,
    output logic [NUM_IRQ-1:0] irr_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_line
            logic pend_q;
            logic prev_q;
            logic rise;
            assign rise = irq_in[g] & ~prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    prev_q <= irq_in[g];
                    if (level_mode)
                        pend_q <= irq_in[g];
                    else if (rise)
                        pend_q <= 1'b1;
                    else if (clr_en && (clr_lvl == LVL_W'(g)))
                        pend_q <= 1'b0;
                end
            end
            assign irr_q[g] = pend_q;
        end
    endgenerate
endmodule

// File: rtl/irq_priority_resolver.sv
module irq_priority_resolver
    import irq_pkg::*;
(
    input  logic [NUM_IRQ-1:0] irr,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] isr,
    input  logic [LVL_W-1:0]   lowest,
    output logic               req_vld,
    output logic [LVL_W-1:0]   req_lvl,
    output logic               top_vld,
    output logic [LVL_W-1:0]   top_lvl,
    output logic               fire
);
    logic [LVL_W:0] req_rank;
    logic [LVL_W:0] isr_rank;

    always_comb begin
        req_rank = prio_rank(irr & ~mask, lowest);
        isr_rank = prio_rank(isr, lowest);
        req_vld  = ~req_rank[LVL_W];
        top_vld  = ~isr_rank[LVL_W];
        req_lvl  = lowest + req_rank[LVL_W-1:0] + LVL_W'(1);
        top_lvl  = lowest + isr_rank[LVL_W-1:0] + LVL_W'(1);
        fire     = req_vld && (req_rank < isr_rank);
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inta,
    input  logic                mode86,
    input  logic                win_vld,
    input  logic [LVL_W-1:0]    win_lvl,
    input  logic [VBASE_W-1:0]  vbase,
    input  logic [CALLLO_W-1:0] call_lo,
    input  logic [BYTE_W-1:0]   call_hi,
    output logic                busy,
    output logic                grant,
    output logic [LVL_W-1:0]    grant_lvl,
    output logic                done,
    output logic [LVL_W-1:0]    done_lvl,
    output logic                vec_valid,
    output logic [BYTE_W-1:0]   vec_data
);
    ack_state_e        state_q, state_d;
    logic [LVL_W-1:0]  lvl_q, lvl_d;
    logic              hit_q, hit_d;
    logic              vval_d;
    logic [BYTE_W-1:0] vdat_d;
    logic              last_pulse;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ACK_IDLE;
            lvl_q     <= LVL_LAST;
            hit_q     <= 1'b0;
            vec_valid <= 1'b0;
            vec_data  <= '0;
        end else begin
            state_q   <= state_d;
            lvl_q     <= lvl_d;
            hit_q     <= hit_d;
            vec_valid <= vval_d;
            vec_data  <= vdat_d;
        end
    end

    // next-state and output process
    always_comb begin
        state_d    = state_q;
        lvl_d      = lvl_q;
        hit_d      = hit_q;
        vval_d     = 1'b0;
        vdat_d     = vec_data;
        last_pulse = 1'b0;
        grant      = 1'b0;
        unique case (state_q)
            ACK_IDLE: begin
                if (inta) begin
                    grant   = win_vld;
                    hit_d   = win_vld;
                    lvl_d   = win_vld ? win_lvl : LVL_LAST;
                    state_d = ACK_SECOND;
                    if (!mode86) begin
                        vval_d = 1'b1;
                        vdat_d = CALL_OPCODE;
                    end
                end
            end
            ACK_SECOND: begin
                if (inta) begin
                    vval_d = 1'b1;
                    if (mode86) begin
                        vdat_d     = {vbase, lvl_q};
                        last_pulse = 1'b1;
                        state_d    = ACK_IDLE;
                    end else begin
                        vdat_d  = {call_lo, lvl_q, 2'b00};
                        state_d = ACK_THIRD;
                    end
                end
            end
            ACK_THIRD: begin
                if (inta) begin
                    vval_d     = 1'b1;
                    vdat_d     = call_hi;
                    last_pulse = 1'b1;
                    state_d    = ACK_IDLE;
                end
            end
            default: state_d = ACK_IDLE;
        endcase
        busy      = (state_q != ACK_IDLE);
        grant_lvl = win_lvl;
        done      = last_pulse && hit_q;
        done_lvl  = lvl_q;
    end
endmodule

// File: rtl/irq_service_reg.sv
module irq_service_reg
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rotate,
    input  logic               grant,
    input  logic [LVL_W-1:0]   grant_lvl,
    input  logic               auto_clr,
    input  logic [LVL_W-1:0]   auto_lvl,
    input  logic               eoi_cmd,
    input  logic               eoi_spec,
    input  logic [LVL_W-1:0]   eoi_lvl,
    input  logic               top_vld,
    input  logic [LVL_W-1:0]   top_lvl,
    output logic [NUM_IRQ-1:0] isr_q,
    output logic [LVL_W-1:0]   lowest_q
);
    logic [NUM_IRQ-1:0] set_vec, clr_vec;
    logic               cmd_hit;
    logic [LVL_W-1:0]   cmd_lvl;
    logic               rot_hit;
    logic [LVL_W-1:0]   rot_lvl;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        cmd_hit = eoi_cmd && (eoi_spec || top_vld);
        cmd_lvl = eoi_spec ? eoi_lvl : top_lvl;
        if (grant)    set_vec[grant_lvl] = 1'b1;
        if (auto_clr) clr_vec[auto_lvl]  = 1'b1;
        if (cmd_hit)  clr_vec[cmd_lvl]   = 1'b1;
        rot_hit = cmd_hit || auto_clr;
        rot_lvl = cmd_hit ? cmd_lvl : auto_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q    <= '0;
            lowest_q <= LVL_LAST;
        end else begin
            isr_q <= (isr_q & ~clr_vec) | set_vec;
            if (!rotate)
                lowest_q <= LVL_LAST;
            else if (rot_hit)
                lowest_q <= rot_lvl;
        end
    end
endmodule

// File: rtl/irq_prio_ack.sv
module irq_prio_ack
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_in,
    input  logic [NUM_IRQ-1:0]  mask_in,
    input  logic                cfg_level,
    input  logic                cfg_mode86,
    input  logic                cfg_aeoi,
    input  logic                cfg_rotate,
    input  logic [VBASE_W-1:0]  cfg_vbase,
    input  logic [CALLLO_W-1:0] cfg_call_lo,
    input  logic [BYTE_W-1:0]   cfg_call_hi,
    input  logic                eoi_cmd,
    input  logic                eoi_spec,
    input  logic [LVL_W-1:0]    eoi_lvl,
    input  logic                inta,
    output logic                int_out,
    output logic                vec_valid,
    output logic [BYTE_W-1:0]   vec_data
);
    logic [NUM_IRQ-1:0] irr_q;
    logic [NUM_IRQ-1:0] isr_q;
    logic [LVL_W-1:0]   lowest_q;
    logic               req_vld, top_vld, fire;
    logic [LVL_W-1:0]   req_lvl, top_lvl;
    logic               ack_busy, grant, done;
    logic [LVL_W-1:0]   grant_lvl, done_lvl;

    irq_request_reg u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .level_mode (cfg_level),
        .clr_en     (grant),
        .clr_lvl    (grant_lvl),
        .irr_q      (irr_q)
    );

    irq_priority_resolver u_res (
        .irr     (irr_q),
        .mask    (mask_in),
        .isr     (isr_q),
        .lowest  (lowest_q),
        .req_vld (req_vld),
        .req_lvl (req_lvl),
        .top_vld (top_vld),
        .top_lvl (top_lvl),
        .fire    (fire)
    );

    irq_ack_fsm u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .inta      (inta),
        .mode86    (cfg_mode86),
        .win_vld   (req_vld),
        .win_lvl   (req_lvl),
        .vbase     (cfg_vbase),
        .call_lo   (cfg_call_lo),
        .call_hi   (cfg_call_hi),
        .busy      (ack_busy),
        .grant     (grant),
        .grant_lvl (grant_lvl),
        .done      (done),
        .done_lvl  (done_lvl),
        .vec_valid (vec_valid),
        .vec_data  (vec_data)
    );

    irq_service_reg u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rotate    (cfg_rotate),
        .grant     (grant),
        .grant_lvl (grant_lvl),
        .auto_clr  (done && cfg_aeoi),
        .auto_lvl  (done_lvl),
        .eoi_cmd   (eoi_cmd),
        .eoi_spec  (eoi_spec),
        .eoi_lvl   (eoi_lvl),
        .top_vld   (top_vld),
        .top_lvl   (top_lvl),
        .isr_q     (isr_q),
        .lowest_q  (lowest_q)
    );

    assign int_out = fire && !ack_busy;
endmodule

// File: rtl/irq_prio_ack_chk.sv
module irq_prio_ack_chk
    import irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                inta,
    input logic                int_out,
    input logic                vec_valid,
    input logic [BYTE_W-1:0]   vec_data,
    input logic                cfg_mode86,
    input logic [VBASE_W-1:0]  cfg_vbase,
    input logic [NUM_IRQ-1:0]  mask_in,
    input logic [NUM_IRQ-1:0]  irr_q,
    input logic [NUM_IRQ-1:0]  isr_q,
    input logic                ack_busy
);
    assert_int_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ack_busy |-> !int_out);

    assert_int_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_q & ~mask_in) != '0));

    assert_type_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(cfg_mode86)) |-> (vec_data[BYTE_W-1:LVL_W] == $past(cfg_vbase)));

    assert_byte_after_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));

    assert_call_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inta) && !$past(ack_busy) && !$past(cfg_mode86)) |-> (vec_valid && vec_data == CALL_OPCODE));

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);
endmodule

bind irq_prio_ack irq_prio_ack_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .inta       (inta),
    .int_out    (int_out),
    .vec_valid  (vec_valid),
    .vec_data   (vec_data),
    .cfg_mode86 (cfg_mode86),
    .cfg_vbase  (cfg_vbase),
    .mask_in    (mask_in),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .ack_busy   (ack_busy)
);

// File: tb/irq_prio_ack_tb_top.sv
module irq_prio_ack_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] mask_in = '0;
    logic       cfg_level = 1'b0;
    logic       cfg_mode86 = 1'b1;
    logic       cfg_aeoi = 1'b1;
    logic       cfg_rotate = 1'b0;
    logic [4:0] cfg_vbase = 5'h14;
    logic [2:0] cfg_call_lo = 3'b101;
    logic [7:0] cfg_call_hi = 8'h12;
    logic       eoi_cmd = 1'b0;
    logic       eoi_spec = 1'b0;
    logic [2:0] eoi_lvl = '0;
    logic       inta = 1'b0;
    logic       int_out;
    logic       vec_valid;
    logic [7:0] vec_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ack dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_in(mask_in),
        .cfg_level(cfg_level), .cfg_mode86(cfg_mode86), .cfg_aeoi(cfg_aeoi),
        .cfg_rotate(cfg_rotate), .cfg_vbase(cfg_vbase), .cfg_call_lo(cfg_call_lo),
        .cfg_call_hi(cfg_call_hi), .eoi_cmd(eoi_cmd), .eoi_spec(eoi_spec),
        .eoi_lvl(eoi_lvl), .inta(inta), .int_out(int_out),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    // {pattern, mask, expected int, expected type byte}, base 5'h14
    localparam logic [31:0] VEC_TABLE [8] = '{
        32'h01_00_01_A0, 32'h80_00_01_A7, 32'h90_00_01_A4, 32'hFF_01_01_A1,
        32'h0C_0C_00_00, 32'h60_20_01_A6, 32'hAA_00_01_A1, 32'h00_00_00_00
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(output logic v, output logic [7:0] b);
        @(negedge clk) inta = 1'b1;
        @(negedge clk) inta = 1'b0;
        v = vec_valid;
        b = vec_data;
    endtask

    task automatic ack86(output logic [7:0] b);
        logic v;
        pulse(v, b);
        pulse(v, b);
    endtask

    task automatic eoi(input logic spec, input logic [2:0] lvl);
        @(negedge clk);
        eoi_cmd = 1'b1; eoi_spec = spec; eoi_lvl = lvl;
        @(negedge clk) eoi_cmd = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] pat);
        @(negedge clk) irq_in = pat;
        @(negedge clk);
    endtask

    task automatic drain();
        logic [7:0] b;
        @(negedge clk);
        irq_in = '0; mask_in = '0; cfg_mode86 = 1'b1; cfg_aeoi = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 9; i++) if (int_out) ack86(b);
        @(negedge clk);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] b;
        logic       v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset int_out", {7'd0, int_out}, 8'h00);
        chk("reset vec_valid", {7'd0, vec_valid}, 8'h00);

        // table walk: fixed priority, edge mode, auto EOI
        for (int i = 0; i < 8; i++) begin
            mask_in = VEC_TABLE[i][23:16];
            set_irq(VEC_TABLE[i][31:24]);
            chk("R4/R3 table int", {7'd0, int_out}, VEC_TABLE[i][15:8]);
            if (VEC_TABLE[i][8]) begin
                ack86(b);
                chk("R4/R7 table vector", b, VEC_TABLE[i][7:0]);
            end
            drain();
        end

        // R3: masked latched line fires after unmask
        mask_in = 8'h08;
        set_irq(8'h08);
        chk("R3 masked held", {7'd0, int_out}, 8'h00);
        @(negedge clk) irq_in = '0; mask_in = '0;
        @(negedge clk);
        chk("R3 unmask fires", {7'd0, int_out}, 8'h01);
        drain();

        // R13: empty acknowledge answers as level 7, ISR untouched
        ack86(b);
        chk("R13 empty vector", b, 8'hA7);
        set_irq(8'h80);
        chk("R13 isr unchanged", {7'd0, int_out}, 8'h01);
        drain();

        // R1 edge latch stays after line falls; R2 level follows line
        set_irq(8'h04);
        @(negedge clk) irq_in = '0;
        repeat (2) @(negedge clk);
        chk("R1 edge latched", {7'd0, int_out}, 8'h01);
        drain();
        cfg_level = 1'b1;
        set_irq(8'h04);
        chk("R2 level high", {7'd0, int_out}, 8'h01);
        @(negedge clk) irq_in = '0;
        @(negedge clk);
        chk("R2 level withdrawn", {7'd0, int_out}, 8'h00);
        cfg_level = 1'b0;
        drain();

        // R9: auto EOI frees the level
        set_irq(8'h04);
        ack86(b);
        chk("R9 vector", b, 8'hA2);
        set_irq(8'h0C);
        chk("R9 isr freed", {7'd0, int_out}, 8'h01);
        drain();

        // nested service, R5 R10 R11 R6
        cfg_aeoi = 1'b0;
        set_irq(8'h08);
        ack86(b);
        chk("R6 grant 3", b, 8'hA3);
        set_irq(8'h28);
        chk("R5 lower blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h2A);
        chk("R5 higher passes", {7'd0, int_out}, 8'h01);
        ack86(b);
        chk("R6 grant 1", b, 8'hA1);
        @(negedge clk);
        chk("R6 irr cleared", {7'd0, int_out}, 8'h00);
        eoi(1'b0, 3'd0);
        @(negedge clk);
        chk("R10 frees top only", {7'd0, int_out}, 8'h00);
        eoi(1'b0, 3'd0);
        @(negedge clk);
        chk("R10 second frees 3", {7'd0, int_out}, 8'h01);
        ack86(b);
        chk("R10 grant 5", b, 8'hA5);
        set_irq(8'h60);
        chk("R11 6 blocked by 5", {7'd0, int_out}, 8'h00);
        eoi(1'b1, 3'd5);
        @(negedge clk);
        chk("R11 specific frees 5", {7'd0, int_out}, 8'h01);
        ack86(b);
        chk("R11 grant 6", b, 8'hA6);
        eoi(1'b1, 3'd6);
        cfg_aeoi = 1'b1;
        drain();

        // R7 first pulse empty, R14 quiet mid-sequence
        set_irq(8'h20);
        pulse(v, b);
        chk("R7 first pulse no byte", {7'd0, v}, 8'h00);
        @(negedge clk) irq_in = 8'h21;
        @(negedge clk);
        chk("R14 quiet mid-seq", {7'd0, int_out}, 8'h00);
        pulse(v, b);
        chk("R7 type byte", b, 8'hA5);
        @(negedge clk);
        chk("R14 int after seq", {7'd0, int_out}, 8'h01);
        drain();

        // R8 three-pulse call mode
        cfg_mode86 = 1'b0;
        set_irq(8'h10);
        pulse(v, b);
        chk("R8 opcode", b, 8'hCD);
        pulse(v, b);
        chk("R8 low byte", b, 8'hB0);
        pulse(v, b);
        chk("R8 high byte", b, 8'h12);
        chk("R8 high valid", {7'd0, v}, 8'h01);
        drain();

        // R12 rotation
        cfg_rotate = 1'b1;
        set_irq(8'h44);
        ack86(b);
        chk("R12 first grant", b, 8'hA2);
        set_irq(8'h46);
        ack86(b);
        chk("R12 rotated grant", b, 8'hA6);
        ack86(b);
        chk("R12 wrap grant", b, 8'hA1);
        cfg_rotate = 1'b0;
        drain();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule